// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects a set of level interrupt request lines, holds per-source enable, pending and priority state, and presents a single request plus a source number to a processor core. A pending bit is latched on the rising edge of a request line, or set and cleared by software. Among the sources that are both enabled and pending, the one with the numerically lowest 3-bit priority level wins, and the lowest source number breaks ties.

A grouping setting decides how many of the three level bits take part in preemption; the rest only order sources that are waiting. The winner is offered to the core only if its preemption key is strictly smaller than that of every handler already running. It must also clear a priority mask threshold and pass a global gate. The core accepts with a one-cycle acknowledge, which clears the source's pending bit and pushes its level onto an active stack. A one-cycle end-of-handler strobe pops that stack, so a waiting request of equal preemption level is taken right after the running handler finishes.

Software reaches the state through a write port (address plus 8-bit data) and an independent combinational read port (address to 32-bit data).

Top module: `nested_irq_ctrl`

## Requirements
- R1: After a synchronous reset every source is disabled, nothing is pending, all levels are 0, the gate is closed (address 0x00 reads 0), the mask is 0, grouping is 7 and `core_req` is low.
- R2: A rising edge on `irq_lines[s]` sets pending bit s one clock later. A line that stays high does not set the bit again after it has been cleared. Pending bits read at 0x18 + k, with bit j of word k standing for source 32k + j.
- R3: Writing source number s to 0x03 / 0x04 sets / clears its enable. Writing s to 0x05 / 0x06 sets / clears its pending bit. A pending bit on a disabled source is kept and is requested once the source is enabled, while a cleared bit is discarded. Enables read at 0x10 + k, with the same bit layout as R2.
- R4: A write to 0x40 + s stores data bits 7:5 as the level of source s. Reading 0x40 + s returns that level in bits 7:5, with bits 4:0 always 0.
- R5: Among enabled pending sources, the lowest level wins; on equal levels the lowest source number wins. `core_vec` carries the winner's number whenever `core_req` is high.
- R6: With a mask value m ≠ 0 (address 0x00 + 1, bits 2:0), a winner whose level is m or greater raises no request. With m = 0, masking is off.
- R7: Writing bit 0 of 0x00 opens (1) or closes (0) the gate. A closed gate holds `core_req` low and leaves every enable bit as it was.
- R8: `ack` while `core_req` is high clears the winner's pending bit and makes its level active. After that, a source at the same or a lower level raises no request.
- R9: The grouping value g (address 0x02, bits 2:0) keeps the top min(g,3) level bits as the preemption key. A request is raised only if the winner's key is strictly below the smallest key among active handlers.
- R10: `eoh` pops the most recently accepted handler. The running key then becomes the smallest key of those that remain, and a waiting request with an equal key is then offered back-to-back.
- R11: The active stack holds 8 handlers and never accepts a push when it is full. An `ack` while `core_req` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 34 | Level request lines, one per source |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Combinational read data |
| ack | input | 1 | One-cycle acceptance strobe from the core |
| eoh | input | 1 | One-cycle end-of-handler strobe from the core |
| core_req | output | 1 | Interrupt request to the core |
| core_vec | output | 6 | Source number of the current winner |

## Verification
The assertions assume that the core acknowledges only a request it can see and sends `eoh` only for a handler it has accepted. They also assume that software names only sources that exist and does not strobe `ack` and `eoh` in the same cycle. The bench drives `ack` only after it has checked that `core_req` is high, or with the gate closed to probe that an unrequested acknowledge is ignored. It issues one `eoh` per accepted handler, and it writes only source numbers below 34.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int PRIO_W = 3;
    localparam int BYTE_W = 8;

    typedef logic [PRIO_W-1:0] lvl_t;

    typedef struct packed {
        logic valid;
        lvl_t key;
    } prio_t;

    localparam logic [7:0] A_GATE      = 8'h00;
    localparam logic [7:0] A_MASK      = 8'h01;
    localparam logic [7:0] A_GROUP     = 8'h02;
    localparam logic [7:0] A_EN_SET    = 8'h03;
    localparam logic [7:0] A_EN_CLR    = 8'h04;
    localparam logic [7:0] A_PEND_SET  = 8'h05;
    localparam logic [7:0] A_PEND_CLR  = 8'h06;
    localparam logic [7:0] A_EN_WORD   = 8'h10;
    localparam logic [7:0] A_PEND_WORD = 8'h18;
    localparam logic [7:0] A_PRIO_BASE = 8'h40;

    // Keep the top min(grp, PRIO_W) bits of a level as its preemption key.
    function automatic lvl_t preempt_key(input lvl_t lvl, input logic [2:0] grp);
        lvl_t keep;
        int   nb;
        nb   = (int'(grp) >= PRIO_W) ? PRIO_W : int'(grp);
        keep = '0;
        for (int b = 0; b < PRIO_W; b++) begin
            if (b >= PRIO_W - nb) keep[b] = 1'b1;
        end
        return lvl & keep;
    endfunction

    function automatic logic mask_pass(input lvl_t lvl, input lvl_t thr);
        return (thr == '0) || (lvl < thr);
    endfunction
endpackage

// File: rtl/nic_regs.sv
module nic_regs
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 34,
    parameter int ID_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            irq,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [7:0]                    rd_addr,
    output logic [31:0]                   rd_data,
    input  logic                          ack_take,
    input  logic [ID_W-1:0]               ack_id,
    output logic [NUM_SRC-1:0]            en_vec,
    output logic [NUM_SRC-1:0]            pend_vec,
    output lvl_t [NUM_SRC-1:0]            lvl_arr,
    output logic                          gate,
    output lvl_t                          mask_thr,
    output logic [2:0]                    grp
);
    localparam int WORDS = (NUM_SRC + 31) / 32;
    localparam int PAD   = WORDS * 32;
    localparam int LOW_W = BYTE_W - PRIO_W;

    logic [NUM_SRC-1:0] irq_q, rise, en_set, en_clr, sw_set, sw_clr, ack_clr, en_q, pend_q;
    lvl_t [NUM_SRC-1:0] lvl_q;
    logic               gate_q;
    lvl_t               mask_q;
    logic [2:0]         grp_q;
    logic [ID_W-1:0]    wr_id;

    assign wr_id = wr_data[ID_W-1:0];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam logic [ID_W-1:0] SID = ID_W'(s);
        assign rise[s]    = irq[s] & ~irq_q[s];
        assign en_set[s]  = wr_en && (wr_addr == A_EN_SET)   && (wr_id == SID);
        assign en_clr[s]  = wr_en && (wr_addr == A_EN_CLR)   && (wr_id == SID);
        assign sw_set[s]  = wr_en && (wr_addr == A_PEND_SET) && (wr_id == SID);
        assign sw_clr[s]  = wr_en && (wr_addr == A_PEND_CLR) && (wr_id == SID);
        assign ack_clr[s] = ack_take && (ack_id == SID);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            lvl_q  <= '0;
            gate_q <= 1'b0;
            mask_q <= '0;
            grp_q  <= 3'd7;
        end else begin
            irq_q  <= irq;
            en_q   <= (en_q | en_set) & ~en_clr;
            pend_q <= (pend_q & ~(sw_clr | ack_clr)) | rise | sw_set;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (wr_en && wr_addr == A_PRIO_BASE + 8'(s))
                    lvl_q[s] <= wr_data[BYTE_W-1 -: PRIO_W];
            end
            if (wr_en && wr_addr == A_GATE)  gate_q <= wr_data[0];
            if (wr_en && wr_addr == A_MASK)  mask_q <= wr_data[PRIO_W-1:0];
            if (wr_en && wr_addr == A_GROUP) grp_q  <= wr_data[2:0];
        end
    end

    logic [PAD-1:0] en_pad, pend_pad;
    assign en_pad   = PAD'(en_q);
    assign pend_pad = PAD'(pend_q);

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_GATE)  rd_data = 32'(gate_q);
        if (rd_addr == A_MASK)  rd_data = 32'(mask_q);
        if (rd_addr == A_GROUP) rd_data = 32'(grp_q);
        for (int k = 0; k < WORDS; k++) begin
            if (rd_addr == A_EN_WORD + 8'(k))   rd_data = en_pad[32*k +: 32];
            if (rd_addr == A_PEND_WORD + 8'(k)) rd_data = pend_pad[32*k +: 32];
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (rd_addr == A_PRIO_BASE + 8'(s))
                rd_data = 32'({lvl_q[s], {LOW_W{1'b0}}});
        end
    end

    assign en_vec   = en_q;
    assign pend_vec = pend_q;
    assign lvl_arr  = lvl_q;
    assign gate     = gate_q;
    assign mask_thr = mask_q;
    assign grp      = grp_q;

    // R8: an accepted source is no longer pending unless re-set the same cycle
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !rise[ack_id] && !sw_set[ack_id]) |=> !pend_q[$past(ack_id)]);

    // R3: software clear with no simultaneous set leaves the bit clear
    assert_sw_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_PEND_CLR && !rise[wr_id]) |=> !pend_q[$past(wr_id)]);
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 34,
    parameter int ID_W    = 6
) (
    input  logic [NUM_SRC-1:0] cand,
    input  lvl_t [NUM_SRC-1:0] lvl_arr,
    output logic               win_valid,
    output logic [ID_W-1:0]    win_id,
    output lvl_t               win_lvl
);
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_lvl   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!win_valid || lvl_arr[i] < win_lvl)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_lvl   = lvl_arr[i];
            end
        end
    end

    // R5: the winner is always a real candidate
    always_comb begin
        if (win_valid) assert_win_is_cand_R5: assert (cand[win_id]);
    end
endmodule

// File: rtl/nic_active_stack.sv
module nic_active_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  lvl_t       push_lvl,
    input  logic       pop,
    input  logic [2:0] grp,
    output prio_t      running,
    output logic       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    lvl_t             stk [DEPTH];
    logic [CNT_W-1:0] count, base;

    assign base = (pop && count != '0) ? count - 1'b1 : count;
    assign full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && base == CNT_W'(i)) stk[i] <= push_lvl;
            end
            if (push && base < CNT_W'(DEPTH)) count <= base + 1'b1;
            else                              count <= base;
        end
    end

    always_comb begin
        lvl_t k;
        running = '{valid: 1'b0, key: '0};
        for (int i = 0; i < DEPTH; i++) begin
            k = preempt_key(stk[i], grp);
            if (CNT_W'(i) < count && (!running.valid || k < running.key))
                running = '{valid: 1'b1, key: k};
        end
    end

    // R11: no push arrives when the stack is full
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    // R10: a lone pop removes exactly one entry
    assert_pop_one_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && count != '0 && !push) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 34,
    parameter int DEPTH   = 8,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic               ack,
    input  logic               eoh,
    output logic               core_req,
    output logic [ID_W-1:0]    core_vec
);
    logic [NUM_SRC-1:0] en_vec, pend_vec;
    lvl_t [NUM_SRC-1:0] lvl_arr;
    logic               gate, win_valid, full, ack_take, beats;
    lvl_t               mask_thr, win_lvl, win_key;
    logic [2:0]         grp;
    logic [ID_W-1:0]    win_id;
    prio_t              running;

    nic_regs #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) regs_i (
        .clk(clk), .rst(rst), .irq(irq_lines),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ack_take(ack_take), .ack_id(win_id),
        .en_vec(en_vec), .pend_vec(pend_vec), .lvl_arr(lvl_arr),
        .gate(gate), .mask_thr(mask_thr), .grp(grp)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) arb_i (
        .cand(en_vec & pend_vec), .lvl_arr(lvl_arr),
        .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl)
    );

    nic_active_stack #(.DEPTH(DEPTH)) stk_i (
        .clk(clk), .rst(rst), .push(ack_take), .push_lvl(win_lvl),
        .pop(eoh), .grp(grp), .running(running), .full(full)
    );

    assign win_key  = preempt_key(win_lvl, grp);
    assign beats    = !running.valid || (win_key < running.key);
    assign core_req = gate && win_valid && mask_pass(win_lvl, mask_thr) && beats && !full;
    assign core_vec = win_valid ? win_id : '0;
    assign ack_take = ack && core_req;

    // R7: a request implies the gate is open
    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        core_req |-> gate);

    // R3: a request names an enabled, pending source
    assert_enabled_R3: assert property (@(posedge clk) disable iff (rst)
        core_req |-> (en_vec[core_vec] && pend_vec[core_vec]));

    // R5: vector is a legal source number
    assert_vec_range_R5: assert property (@(posedge clk) disable iff (rst)
        core_req |-> (int'(core_vec) < NUM_SRC));

    // R6: a masked level never reaches the core
    assert_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (core_req && mask_thr != '0) |-> (lvl_arr[core_vec] < mask_thr));
endmodule

// File: tb/nested_irq_ctrl_tb_top.sv
module nested_irq_ctrl_tb_top;
    localparam int NS = 34;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_lines = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          ack = 1'b0;
    logic          eoh = 1'b0;
    logic          core_req;
    logic [5:0]    core_vec;

    always #4 clk = ~clk;

    nested_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ack(ack), .eoh(eoh), .core_req(core_req), .core_vec(core_vec)
    );

    typedef struct {
        bit          is_rd;
        logic [31:0] val;
        logic        req;
        int          vec;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: compares after each rising edge, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (it.is_rd) begin
                    if (rd_data !== it.val) begin
                        n_fail++;
                        $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.val);
                    end
                end else if (core_req !== it.req || (it.req && int'(core_vec) != it.vec)) begin
                    n_fail++;
                    $display("FAIL %s req/vec actual=%b/%0d expected=%b/%0d",
                             it.tag, core_req, core_vec, it.req, it.vec);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic exp_out(input logic r, input int v, input string tag);
        item_t it;
        @(negedge clk);
        it.is_rd = 0; it.val = '0; it.req = r; it.vec = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] v, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.is_rd = 1; it.val = v; it.req = 0; it.vec = 0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_eoh();
        @(negedge clk); eoh = 1'b1;
        @(negedge clk); eoh = 1'b0;
    endtask

    task automatic setup_src(input int s, input int lvl);
        wr(8'h40 + 8'(s), 8'(lvl << 5));
        wr(8'h03, 8'(s));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        exp_out(0, 0, "R1");
        exp_rd(8'h18, 32'h0, "R1 pending");
        exp_rd(8'h10, 32'h0, "R1 enable");
        exp_rd(8'h00, 32'h0, "R1 gate");
        exp_rd(8'h02, 32'h7, "R1 group");

        // R4 only top three bits kept
        wr(8'h45, 8'hFF);
        exp_rd(8'h45, 32'hE0, "R4");

        // R2 edge sets pending, R5 vector
        wr(8'h00, 8'h01);
        setup_src(3, 4);
        @(negedge clk); irq_lines[3] = 1'b1;
        exp_rd(8'h18, 32'h8, "R2");
        exp_out(1, 3, "R5 single");

        // R6 mask
        wr(8'h01, 8'd4);
        exp_out(0, 0, "R6 mask equal");
        wr(8'h01, 8'd5);
        exp_out(1, 3, "R6 mask above");
        wr(8'h01, 8'd0);
        exp_out(1, 3, "R6 mask off");

        // R7 gate
        wr(8'h00, 8'h00);
        exp_out(0, 0, "R7 gate closed");
        exp_rd(8'h10, 32'h8, "R7 enables kept");
        wr(8'h00, 8'h01);

        // R3 pending on a disabled source
        wr(8'h05, 8'd33);
        wr(8'h40 + 8'd33, 8'h40);
        exp_rd(8'h19, 32'h2, "R3 kept while disabled");
        exp_out(1, 3, "R3 disabled ignored");
        wr(8'h03, 8'd33);
        exp_out(1, 33, "R3 enabled now");

        // R5 tie on level, lower number wins
        setup_src(10, 2);
        wr(8'h05, 8'd10);
        exp_out(1, 10, "R5 tie");
        wr(8'h06, 8'd10);
        exp_out(1, 33, "R3 clear discards");
        exp_rd(8'h18, 32'h8, "R3 clear read");

        // R8 acceptance
        pulse_ack();
        exp_rd(8'h19, 32'h0, "R8 pending cleared");
        exp_out(0, 0, "R8 lower blocked");

        // R9 preemption and grouping
        setup_src(7, 1);
        wr(8'h05, 8'd7);
        exp_out(1, 7, "R9 preempt");
        wr(8'h02, 8'd1);
        exp_out(0, 0, "R9 same group key");
        wr(8'h02, 8'd3);
        exp_out(1, 7, "R9 full key");
        pulse_ack();
        exp_out(0, 0, "R8 nested");

        // R10 pop and tail chaining
        pulse_eoh();
        exp_out(0, 0, "R10 back to level 2");
        setup_src(12, 2);
        wr(8'h05, 8'd12);
        exp_out(0, 0, "R10 equal waits");
        pulse_eoh();
        exp_out(1, 12, "R10 tail chain");
        pulse_ack();
        exp_out(0, 0, "R10 running 2");
        pulse_eoh();
        exp_out(1, 3, "R10 idle again");

        // R11 ack without request ignored
        wr(8'h00, 8'h00);
        pulse_ack();
        wr(8'h00, 8'h01);
        exp_rd(8'h18, 32'h8, "R11 ack ignored");
        exp_out(1, 3, "R11 ack ignored req");

        // R2 level held does not re-pend
        wr(8'h06, 8'd3);
        exp_rd(8'h18, 32'h0, "R2 no re-pend");

        // R11 fill the stack
        for (int i = 0; i < 8; i++) begin
            setup_src(20 + i, 7 - i);
            wr(8'h05, 8'(20 + i));
            exp_out(1, 20 + i, "R11 fill");
            pulse_ack();
        end
        setup_src(28, 0);
        wr(8'h05, 8'd28);
        exp_out(0, 0, "R11 full");
        pulse_eoh();
        exp_out(1, 28, "R11 after pop");
        for (int i = 0; i < 7; i++) pulse_eoh();
        exp_out(1, 28, "R11 drained");

        repeat (3) @(negedge clk);
        report();
    end
endmodule